// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This controller arbitrates eleven interrupt sources for a small 8-bit processor core: five legacy sources whose enable and priority bits arrive on input pins, and six newer sources fed by a serial channel and a two-channel DMA engine. The six newer sources have their own enable and priority registers. Software reaches these registers through a simple address/data port. Each source has one priority bit. A high-priority source always outranks a low-priority one. Within one level, the source with the lowest vector address wins.

For the serial-channel sources, the controller picks which status flags raise each interrupt. The choice depends on whether the processor or the DMA engine currently drives the channel. The controller offers the core a request, an 8-bit vector address and the level of that request. An acknowledge strobe records that the offered level is now in service. A return strobe unwinds the most recent level. A low-priority service can be preempted only by a high-priority request. A high-priority service cannot be preempted at all.

Top module: `vint_ctrl`

## Requirements
- R1: After a synchronous reset, both source registers read 00h, no request is offered, and neither level is in service.
- R2: The enable register is at address C8h and the priority register is at address F8h. Bits 5:0 of each are writable and take the written value on the clock edge where `reg_we` is high. Bits 7:6 always read 0. A read of any other address returns 00h, and reads are combinational.
- R3: Register bit to source and vector mapping: bit 0 serial receive valid 2Bh, bit 1 serial receive error 33h, bit 2 DMA channel 0 done 3Bh, bit 3 serial transmit valid 43h, bit 5 serial transmit error 4Bh, bit 4 DMA channel 1 done 53h. Legacy source n (bit n of the legacy inputs) uses vector 03h + 8·n.
- R4: A source can raise a request only when three conditions hold together: its trigger is active, its enable bit is 1, and `glb_en` is 1.
- R5: Receive valid triggers on `rx_fifo_ne` when `ser_dma_mode`=0, and on `rx_done` when `ser_dma_mode`=1.
- R6: Transmit valid triggers on `tx_fifo_nf` when `ser_dma_mode`=0, and on `tx_done` when `ser_dma_mode`=1.
- R7: Transmit error triggers on `tx_noack` or `tx_collide` in either mode. When `ser_dma_mode`=1 it also triggers on `tx_underrun`.
- R8: Receive error triggers on any of `rx_crc_err`, `rx_overrun`, `rx_abort` or `rx_align_err` in both modes. Each DMA source triggers on its channel's done input.
- R9: A pending source with priority bit 1 is offered ahead of any source with priority bit 0. `irq_level` shows the level of the offered source (1 = high).
- R10: Within one level, the pending source with the lowest vector address is offered.
- R11: When `irq_ack` is high while a request is offered, the offered level is marked in service on that edge. With nothing in service, either level may be offered. With low in service, only high requests are offered. With high in service, no request is offered.
- R12: `irq_ret` clears the high in-service flag if it is set, otherwise the low one. If `irq_ret` and `irq_ack` are high together, the return is applied and the acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data (combinational) |
| glb_en | input | 1 | Global interrupt enable |
| leg_req | input | 5 | Legacy source requests |
| leg_en | input | 5 | Legacy source enables |
| leg_pri | input | 5 | Legacy source priority bits |
| ser_dma_mode | input | 1 | 1 = serial channel under DMA control |
| rx_fifo_ne | input | 1 | Receive FIFO not empty |
| rx_done | input | 1 | Receive DMA transfer done |
| rx_crc_err | input | 1 | Receive CRC error |
| rx_overrun | input | 1 | Receive overrun |
| rx_abort | input | 1 | Receive abort |
| rx_align_err | input | 1 | Receive alignment error |
| tx_fifo_nf | input | 1 | Transmit FIFO not full |
| tx_done | input | 1 | Transmit DMA transfer done |
| tx_noack | input | 1 | Transmit no-acknowledge |
| tx_collide | input | 1 | Transmit collision detected |
| tx_underrun | input | 1 | Transmit underrun |
| dma0_done | input | 1 | DMA channel 0 done |
| dma1_done | input | 1 | DMA channel 1 done |
| irq_ack | input | 1 | Core accepts the offered request |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Request to the core |
| irq_vector | output | 8 | Vector address of the offered source |
| irq_level | output | 1 | Level of the offered source (1 = high) |
| svc_hi | output | 1 | High level in service |
| svc_lo | output | 1 | Low level in service |

## Verification
The request path is combinational. A wrong enable or priority bit therefore shows up on `irq_vector` or `irq_level` in the same cycle as the next register read or flag change. A swapped bit between register order and vector order shows up as the wrong vector once only the transmit-error or only the DMA-1 enable is set. A corrupted in-service flag appears one edge after the acknowledge or return. It shows on `svc_hi`/`svc_lo`, and at once as a wrongly blocked or wrongly offered request. The bench therefore checks every acknowledge and return against both the flags and the next offered request.

// File: rtl/vint_pkg.sv
package vint_pkg;
    localparam int N_LEG = 5;
    localparam int N_NEW = 6;
    localparam int N_SRC = N_LEG + N_NEW;
    localparam int IDX_W = $clog2(N_SRC);
    localparam logic [7:0] VEC_BASE = 8'h03;
    localparam int VEC_STEP_SH = 3;
    localparam logic [7:0] ADDR_EN  = 8'hC8;
    localparam logic [7:0] ADDR_PRI = 8'hF8;

    typedef struct packed {
        logic             valid;
        logic             level;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } svc_t;

    // vector address of a source in polling order
    function automatic logic [7:0] vec_of(input logic [IDX_W-1:0] idx);
        return VEC_BASE + (8'(idx) << VEC_STEP_SH);
    endfunction

    // register bit order -> polling order (transmit error polls before DMA1)
    function automatic logic [N_NEW-1:0] reg_to_poll(input logic [N_NEW-1:0] r);
        return {r[4], r[5], r[3:0]};
    endfunction

    // lowest set bit of a source mask
    function automatic pick_t first_set(input logic [N_SRC-1:0] m, input logic lvl);
        pick_t p;
        p = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (m[i]) begin
                p.valid = 1'b1;
                p.level = lvl;
                p.idx   = IDX_W'(i);
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/vint_regs.sv
module vint_regs
    import vint_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             we,
    output logic [7:0]       rdata,
    output logic [N_NEW-1:0] en_q,
    output logic [N_NEW-1:0] pri_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            pri_q <= '0;
        end else if (we) begin
            if (addr == ADDR_EN)  en_q  <= wdata[N_NEW-1:0];
            if (addr == ADDR_PRI) pri_q <= wdata[N_NEW-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_EN)       rdata[N_NEW-1:0] = en_q;
        else if (addr == ADDR_PRI) rdata[N_NEW-1:0] = pri_q;
    end

    // R2
    en_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == ADDR_EN) |=> (en_q == $past(wdata[N_NEW-1:0])));
    // R2
    pri_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!we || addr != ADDR_PRI) |=> $stable(pri_q));
endmodule

// File: rtl/vint_trigger.sv
module vint_trigger
    import vint_pkg::*;
(
    input  logic             dma_mode,
    input  logic             rx_fifo_ne,
    input  logic             rx_done,
    input  logic             rx_crc_err,
    input  logic             rx_overrun,
    input  logic             rx_abort,
    input  logic             rx_align_err,
    input  logic             tx_fifo_nf,
    input  logic             tx_done,
    input  logic             tx_noack,
    input  logic             tx_collide,
    input  logic             tx_underrun,
    input  logic             dma0_done,
    input  logic             dma1_done,
    output logic [N_NEW-1:0] trig_poll   // polling order: rxv,rxe,dma0,txv,txe,dma1
);
    logic rxv, rxe, txv, txe;

    always_comb begin
        rxv = dma_mode ? rx_done : rx_fifo_ne;
        txv = dma_mode ? tx_done : tx_fifo_nf;
        rxe = rx_crc_err | rx_overrun | rx_abort | rx_align_err;
        txe = tx_noack | tx_collide | (dma_mode & tx_underrun);
        trig_poll = {dma1_done, txe, txv, dma0_done, rxe, rxv};
    end
endmodule

// File: rtl/vint_arbiter.sv
module vint_arbiter
    import vint_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] pri,
    input  logic             allow_hi,
    input  logic             allow_lo,
    output pick_t            pick
);
    pick_t p_hi, p_lo;

    always_comb begin
        p_hi = first_set(pend & pri, 1'b1);
        p_lo = first_set(pend & ~pri, 1'b0);
        pick = '0;
        if (allow_hi && p_hi.valid)      pick = p_hi;
        else if (allow_lo && p_lo.valid) pick = p_lo;
    end

    // R9
    hi_first_chk: assert property (@(posedge clk) disable iff (rst)
        (allow_hi && |(pend & pri)) |-> (pick.valid && pick.level));
    // R10
    lowest_idx_chk: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> ((pend & ((N_SRC'(1) << pick.idx) - N_SRC'(1))
                         & (pick.level ? pri : ~pri)) == '0));
endmodule

// File: rtl/vint_nest.sv
module vint_nest
    import vint_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ack,
    input  logic ret,
    input  pick_t pick,
    output svc_t svc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            svc <= '0;
        end else if (ret) begin
            if (svc.hi) svc.hi <= 1'b0;
            else        svc.lo <= 1'b0;
        end else if (ack && pick.valid) begin
            if (pick.level) svc.hi <= 1'b1;
            else            svc.lo <= 1'b1;
        end
    end

    // R12
    pop_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (ret && svc.hi) |=> (!svc.hi && svc.lo == $past(svc.lo)));
    // R12
    pop_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (ret && !svc.hi) |=> (svc == '0));
    // R11
    push_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !ret && pick.valid && pick.level) |=> svc.hi);
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
    import vint_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_we,
    output logic [7:0] reg_rdata,
    input  logic       glb_en,
    input  logic [4:0] leg_req,
    input  logic [4:0] leg_en,
    input  logic [4:0] leg_pri,
    input  logic       ser_dma_mode,
    input  logic       rx_fifo_ne,
    input  logic       rx_done,
    input  logic       rx_crc_err,
    input  logic       rx_overrun,
    input  logic       rx_abort,
    input  logic       rx_align_err,
    input  logic       tx_fifo_nf,
    input  logic       tx_done,
    input  logic       tx_noack,
    input  logic       tx_collide,
    input  logic       tx_underrun,
    input  logic       dma0_done,
    input  logic       dma1_done,
    input  logic       irq_ack,
    input  logic       irq_ret,
    output logic       irq_req,
    output logic [7:0] irq_vector,
    output logic       irq_level,
    output logic       svc_hi,
    output logic       svc_lo
);
    logic [N_NEW-1:0] en_q, pri_q, trig_poll;
    logic [N_SRC-1:0] pend, pri_all;
    pick_t            pick;
    svc_t             svc;

    vint_regs u_regs (
        .clk(clk), .rst(rst), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
        .rdata(reg_rdata), .en_q(en_q), .pri_q(pri_q)
    );

    vint_trigger u_trig (
        .dma_mode(ser_dma_mode), .rx_fifo_ne(rx_fifo_ne), .rx_done(rx_done),
        .rx_crc_err(rx_crc_err), .rx_overrun(rx_overrun), .rx_abort(rx_abort),
        .rx_align_err(rx_align_err), .tx_fifo_nf(tx_fifo_nf), .tx_done(tx_done),
        .tx_noack(tx_noack), .tx_collide(tx_collide), .tx_underrun(tx_underrun),
        .dma0_done(dma0_done), .dma1_done(dma1_done), .trig_poll(trig_poll)
    );

    always_comb begin
        pend    = {trig_poll & reg_to_poll(en_q), leg_req & leg_en}
                  & {N_SRC{glb_en}};
        pri_all = {reg_to_poll(pri_q), leg_pri};
    end

    vint_arbiter u_arb (
        .clk(clk), .rst(rst), .pend(pend), .pri(pri_all),
        .allow_hi(!svc.hi), .allow_lo(!svc.hi && !svc.lo), .pick(pick)
    );

    vint_nest u_nest (
        .clk(clk), .rst(rst), .ack(irq_ack), .ret(irq_ret), .pick(pick), .svc(svc)
    );

    always_comb begin
        irq_req    = pick.valid;
        irq_vector = pick.valid ? vec_of(pick.idx) : 8'h00;
        irq_level  = pick.valid & pick.level;
        svc_hi     = svc.hi;
        svc_lo     = svc.lo;
    end

    // R4
    glb_off_chk: assert property (@(posedge clk) disable iff (rst)
        !glb_en |-> !irq_req);
    // R11
    hi_svc_block_chk: assert property (@(posedge clk) disable iff (rst)
        svc_hi |-> !irq_req);
    // R11
    lo_svc_only_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (svc_lo && irq_req) |-> irq_level);
    // R3
    vec_align_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vector[2:0] == 3'b011 && irq_vector <= 8'h53));
endmodule

// File: tb/sim_vint_ctrl.sv
module sim_vint_ctrl;
    localparam real HALF = 2.5;   // 200 MHz

    logic clk = 0, rst = 1;
    logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
    logic reg_we = 0, glb_en = 0;
    logic [4:0] leg_req = 0, leg_en = 0, leg_pri = 0;
    logic ser_dma_mode = 0;
    logic rx_fifo_ne = 0, rx_done = 0, rx_crc_err = 0, rx_overrun = 0, rx_abort = 0, rx_align_err = 0;
    logic tx_fifo_nf = 0, tx_done = 0, tx_noack = 0, tx_collide = 0, tx_underrun = 0;
    logic dma0_done = 0, dma1_done = 0, irq_ack = 0, irq_ret = 0;
    logic irq_req, irq_level, svc_hi, svc_lo;
    logic [7:0] irq_vector;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(HALF) clk = ~clk;

    vint_ctrl u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_flags();
        rx_fifo_ne = 0; rx_done = 0; rx_crc_err = 0; rx_overrun = 0; rx_abort = 0;
        rx_align_err = 0; tx_fifo_nf = 0; tx_done = 0; tx_noack = 0; tx_collide = 0;
        tx_underrun = 0; dma0_done = 0; dma1_done = 0; leg_req = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a; #1;
        check(req, reg_rdata, exp);
    endtask

    // offered request as {req, level, vector}
    task automatic req_chk(input string req, input logic r, input logic l, input logic [7:0] v);
        #1;
        check(req, {irq_req, irq_level, irq_vector}, {r, l, v});
    endtask

    task automatic pulse_ack(input logic with_ret);
        @(negedge clk); irq_ack = 1; irq_ret = with_ret;
        @(negedge clk); irq_ack = 0; irq_ret = 0; #1;
    endtask

    task automatic pulse_ret();
        @(negedge clk); irq_ret = 1;
        @(negedge clk); irq_ret = 0; #1;
    endtask

    task automatic t_reset();
        rd_chk("R1 enable reg", 8'hC8, 8'h00);
        rd_chk("R1 priority reg", 8'hF8, 8'h00);
        check("R1 no request", irq_req, 0);
        check("R1 svc flags", {svc_hi, svc_lo}, 2'b00);
    endtask

    task automatic t_regs();
        wr(8'hC8, 8'hFF);
        rd_chk("R2 enable reserved bits", 8'hC8, 8'h3F);
        wr(8'hF8, 8'hA5);
        rd_chk("R2 priority write", 8'hF8, 8'h25);
        rd_chk("R2 enable unchanged", 8'hC8, 8'h3F);
        wr(8'h10, 8'h11);
        rd_chk("R2 other address", 8'h10, 8'h00);
        rd_chk("R2 stray write ignored", 8'hF8, 8'h25);
        wr(8'hC8, 8'h00); wr(8'hF8, 8'h00);
    endtask

    task automatic t_legacy();
        @(negedge clk); glb_en = 1; leg_en = 5'h1F; leg_req = 5'b10110; leg_pri = 0;
        req_chk("R10 legacy lowest vector", 1, 0, 8'h0B);
        leg_pri = 5'b10000;
        req_chk("R9 legacy high wins", 1, 1, 8'h23);
        leg_pri = 5'b10100;
        req_chk("R10 lowest within high", 1, 1, 8'h13);
        leg_en = 5'b01011; leg_pri = 0;
        req_chk("R4 legacy enable mask", 1, 0, 8'h0B);
        clear_flags(); leg_en = 0; leg_pri = 0;
    endtask

    task automatic t_newmap();
        wr(8'hC8, 8'h3F);
        @(negedge clk); clear_flags(); rx_fifo_ne = 1; req_chk("R3 rx valid", 1, 0, 8'h2B);
        clear_flags(); rx_crc_err = 1; req_chk("R3 rx error", 1, 0, 8'h33);
        clear_flags(); dma0_done = 1;  req_chk("R3 dma0", 1, 0, 8'h3B);
        clear_flags(); tx_fifo_nf = 1; req_chk("R3 tx valid", 1, 0, 8'h43);
        clear_flags(); tx_noack = 1;   req_chk("R3 tx error", 1, 0, 8'h4B);
        clear_flags(); dma1_done = 1;  req_chk("R3 dma1", 1, 0, 8'h53);
        tx_collide = 1; req_chk("R10 tx error before dma1", 1, 0, 8'h4B);
        wr(8'hC8, 8'h10); #1; req_chk("R3 bit4 enables dma1", 1, 0, 8'h53);
        wr(8'hC8, 8'h20); #1; req_chk("R3 bit5 enables tx error", 1, 0, 8'h4B);
        wr(8'hF8, 8'h10); wr(8'hC8, 8'h30); #1;
        req_chk("R9 priority bit4 raises dma1", 1, 1, 8'h53);
        wr(8'hF8, 8'h00); wr(8'hC8, 8'h3F);
        @(negedge clk); clear_flags();
    endtask

    task automatic t_mode();
        @(negedge clk); ser_dma_mode = 0; rx_done = 1;
        req_chk("R5 rx done ignored in cpu mode", 0, 0, 8'h00);
        ser_dma_mode = 1; req_chk("R5 rx done in dma mode", 1, 0, 8'h2B);
        rx_done = 0; rx_fifo_ne = 1;
        req_chk("R5 fifo flag ignored in dma mode", 0, 0, 8'h00);
        clear_flags(); tx_done = 1; req_chk("R6 tx done in dma mode", 1, 0, 8'h43);
        ser_dma_mode = 0; req_chk("R6 tx done ignored in cpu mode", 0, 0, 8'h00);
        clear_flags(); tx_underrun = 1;
        req_chk("R7 underrun ignored in cpu mode", 0, 0, 8'h00);
        ser_dma_mode = 1; req_chk("R7 underrun in dma mode", 1, 0, 8'h4B);
        clear_flags(); tx_collide = 1; req_chk("R7 collision in dma mode", 1, 0, 8'h4B);
        clear_flags(); rx_align_err = 1; req_chk("R8 align error dma mode", 1, 0, 8'h33);
        ser_dma_mode = 0; rx_align_err = 0; rx_abort = 1;
        req_chk("R8 abort cpu mode", 1, 0, 8'h33);
        clear_flags(); rx_overrun = 1; req_chk("R8 overrun cpu mode", 1, 0, 8'h33);
        clear_flags();
    endtask

    task automatic t_gating();
        @(negedge clk); dma0_done = 1; glb_en = 0;
        req_chk("R4 global enable off", 0, 0, 8'h00);
        glb_en = 1; req_chk("R4 global enable on", 1, 0, 8'h3B);
        wr(8'hC8, 8'h3B); #1;
        req_chk("R4 source enable off", 0, 0, 8'h00);
        wr(8'hC8, 8'h3F);
        @(negedge clk); clear_flags();
    endtask

    task automatic t_nest();
        @(negedge clk); leg_en = 5'h1F; leg_pri = 5'b11000; leg_req = 5'b00001;
        req_chk("R11 idle offers low", 1, 0, 8'h03);
        pulse_ack(0);
        check("R11 low pushed", {svc_hi, svc_lo}, 2'b01);
        req_chk("R11 low blocks low", 0, 0, 8'h00);
        leg_req = 5'b10001;
        req_chk("R11 high preempts low", 1, 1, 8'h23);
        pulse_ack(0);
        check("R11 high pushed", {svc_hi, svc_lo}, 2'b11);
        leg_req = 5'b11001;
        req_chk("R11 high not preempted", 0, 0, 8'h00);
        pulse_ret();
        check("R12 pop high first", {svc_hi, svc_lo}, 2'b01);
        req_chk("R12 high offered again", 1, 1, 8'h1B);
        pulse_ack(1);
        check("R12 ret beats ack", {svc_hi, svc_lo}, 2'b00);
        pulse_ret();
        check("R12 empty ret harmless", {svc_hi, svc_lo}, 2'b00);
        leg_pri = 0; leg_req = 5'b00100;
        req_chk("R11 idle again offers low", 1, 0, 8'h13);
        pulse_ack(0);
        pulse_ret();
        check("R12 pop low", {svc_hi, svc_lo}, 2'b00);
        clear_flags();
    endtask

    initial begin
        #(HALF * 2 * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_legacy();
        t_newmap();
        t_mode();
        t_gating();
        t_nest();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule